// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state under software control. After reset it holds clock enable high and drives NOP commands. It counts out a power-up settling period given as a parameter in clock cycles. Software then steps through the initialization by writing a small control register. That write turns the controller on and arms one command at a time: precharge-all, auto-refresh or mode-register load.

Each armed command is issued by a dummy write of any data to the SDRAM address window. For a mode-register load, the value loaded comes from the address of that write, not its data. CPU address bits [13:1] drive the SDRAM address pins and bits [15:14] drive the bank pins. The bank value picks the base mode register (00) or the extended one (10). If the settling period or the minimum gap after the previous command has not yet passed, the dummy write is stalled until the command can go out.

A read-only completion flag in the register tells software, and the rest of the controller, that the sequence has finished. Normal accesses and self-refresh must wait for that flag. An error flag reports when the CAS latency written by a base mode-register load disagrees with the separate CAS latency configuration input.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `sd_cke` is 1, the command pins show NOP, and `cas_err` is 0. `sd_cke` stays 1 at all times.
- R2: The control register layout is fixed. Bit 4 enables the controller. Bit 3 is the read-only completion flag. Bit 2 arms the mode-register load, bit 1 arms auto-refresh and bit 0 arms precharge-all. A write loads bits 4, 2, 1 and 0.
- R3: When enabled and armed, a dummy write that is not stalled drives the command for exactly the one cycle after the accepting edge. The command encodings on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, precharge-all 0010, auto-refresh 0001 and mode load 0000.
- R4: A mode load drives `sd_a` = CPU address [13:1] and `sd_ba` = CPU address [15:14]. Precharge-all drives `sd_a[10]`=1 and bank 0.
- R5: When several commands are armed, precharge-all is issued first, then auto-refresh, then mode load.
- R6: No command leaves the block before PWRUP_CYC cycles after reset. A triggering write held from earlier is accepted on clock edge PWRUP_CYC+1.
- R7: The next command is at least TRP_CYC cycles after precharge-all, TRFC_CYC cycles after auto-refresh and TMRD_CYC cycles after a mode load. A triggering write is stalled for the shortfall and issued on the first allowed edge.
- R8: A dummy write while the controller is disabled or nothing is armed is not stalled and issues no command.
- R9: The completion flag is set by a mode load to bank 00 only after both a precharge-all and an auto-refresh have been issued since the controller was enabled. A mode load to any other bank does not set it.
- R10: Writing 0 to the enable bit clears the completion flag, the error flag and the record of issued commands.
- R11: A mode load to bank 00 sets `cas_err` when `sd_a[6:4]` differs from {0, `cas_cfg`} and clears it when they match. Other commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 5 | Control register write data |
| reg_rdata | output | 5 | Control register read data |
| mem_wr | input | 1 | Write to the SDRAM window |
| mem_addr | input | ADDR_W-1 | CPU byte address bits [ADDR_W-1:1] of the write |
| mem_stall | output | 1 | Holds off the triggering write |
| cas_cfg | input | 2 | Configured CAS latency |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | ADDR_W-3 | SDRAM address |
| cas_err | output | 1 | CAS latency mismatch flag |

## Verification
A wrong wait counter shows up at the ports within a single command gap. A command lands one cycle early or late against the edge the bench predicts, or `mem_stall` fails to release on that edge. A wrong arm priority or a lost record of an issued command shows in the next command encoding on the pins, or in the completion flag bit on the following register read. A bad address slice or CAS comparison shows on `sd_a`, `sd_ba` or `cas_err` in the cycle right after the accepting edge.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int PWRUP_CYC = 20000,
  parameter int TRP_CYC   = 3,
  parameter int TRFC_CYC  = 12,
  parameter int TMRD_CYC  = 2,
  parameter int ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_wdata,
  output logic [4:0]        reg_rdata,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:1] mem_addr,
  output logic              mem_stall,
  input  logic [1:0]        cas_cfg,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-4:0] sd_a,
  output logic              cas_err
);
  localparam int SA_W  = ADDR_W - 3;
  localparam int PW_W  = $clog2(PWRUP_CYC + 1);
  localparam int GMAX  = (TRFC_CYC > TRP_CYC) ? ((TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC)
                                              : ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC);
  localparam int GW    = $clog2(GMAX + 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  logic            en, done, pre_seen, ref_seen;
  logic [2:0]      arm;
  logic [PW_W-1:0] pwr_cnt;
  logic [GW-1:0]   gap_cnt;
  logic [3:0]      cmd_q;
  logic [SA_W-1:0] a_q;
  logic [1:0]      ba_q;
  logic            unused_wbit;

  wire armed  = en & (|arm);
  wire pwr_ok = (pwr_cnt == '0);
  wire busy   = (gap_cnt != '0);
  wire go     = mem_wr & armed & pwr_ok & ~busy;
  wire [1:0] wr_ba = mem_addr[ADDR_W-1 -: 2];
  wire [SA_W-1:0] wr_a = mem_addr[ADDR_W-3:1];

  assign unused_wbit = reg_wdata[3];
  assign mem_stall = mem_wr & armed & (~pwr_ok | busy);
  assign reg_rdata = {en, done, arm};
  assign sd_cke = 1'b1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_a  = a_q;
  assign sd_ba = ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      done     <= 1'b0;
      arm      <= '0;
      pre_seen <= 1'b0;
      ref_seen <= 1'b0;
      cas_err  <= 1'b0;
      pwr_cnt  <= PW_W'(PWRUP_CYC);
      gap_cnt  <= '0;
      cmd_q    <= C_NOP;
      a_q      <= '0;
      ba_q     <= '0;
    end else begin
      if (!pwr_ok) pwr_cnt <= pwr_cnt - 1'b1;
      if (busy) gap_cnt <= gap_cnt - 1'b1;
      cmd_q <= C_NOP;
      a_q   <= '0;
      ba_q  <= '0;
      if (go) begin
        if (arm[0]) begin
          cmd_q    <= C_PRE;
          a_q[10]  <= 1'b1;
          pre_seen <= 1'b1;
          gap_cnt  <= GW'(TRP_CYC - 1);
        end else if (arm[1]) begin
          cmd_q    <= C_REF;
          ref_seen <= 1'b1;
          gap_cnt  <= GW'(TRFC_CYC - 1);
        end else begin
          cmd_q   <= C_MRS;
          a_q     <= wr_a;
          ba_q    <= wr_ba;
          gap_cnt <= GW'(TMRD_CYC - 1);
          if (wr_ba == 2'b00) begin
            cas_err <= (wr_a[6:4] != {1'b0, cas_cfg});
            if (pre_seen && ref_seen) done <= 1'b1;
          end
        end
      end
      if (reg_wr) begin
        en  <= reg_wdata[4];
        arm <= reg_wdata[2:0];
        if (!reg_wdata[4]) begin
          done     <= 1'b0;
          cas_err  <= 1'b0;
          pre_seen <= 1'b0;
          ref_seen <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int PWRUP_CYC = 20000,
  parameter int TRP_CYC   = 3,
  parameter int TRFC_CYC  = 12,
  parameter int TMRD_CYC  = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_wr,
  input logic       mem_stall,
  input logic       en,
  input logic       done,
  input logic [3:0] cmd,
  input logic       a10,
  input logic [2:0] cl_field,
  input logic [1:0] ba,
  input logic [1:0] cas_cfg,
  input logic       cas_err
);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  int         since_rst, since_cmd;
  logic [3:0] last_cmd;
  logic       have_last;
  int         need;

  always_comb begin
    case (last_cmd)
      C_PRE:   need = TRP_CYC;
      C_REF:   need = TRFC_CYC;
      default: need = TMRD_CYC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
      since_cmd <= 0;
      last_cmd  <= C_NOP;
      have_last <= 1'b0;
    end else begin
      if (since_rst <= PWRUP_CYC) since_rst <= since_rst + 1;
      if (cmd != C_NOP) begin
        since_cmd <= 1;
        last_cmd  <= cmd;
        have_last <= 1'b1;
      end else if (since_cmd < TRFC_CYC + TRP_CYC + TMRD_CYC) begin
        since_cmd <= since_cmd + 1;
      end
    end
  end

  // R8
  stall_only_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |-> (mem_wr && en));

  // R3
  cmd_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP) |-> ($past(mem_wr) && $past(en)));

  // R6
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= PWRUP_CYC) |-> (cmd == C_NOP));

  // R7
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd != C_NOP) && have_last) |-> (since_cmd >= need));

  // R4
  pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> (a10 && ba == 2'b00));

  // R9
  done_from_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cmd == C_MRS && ba == 2'b00));

  // R10
  done_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> en);

  // R11
  cas_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_err) |-> (cmd == C_MRS && ba == 2'b00 && cl_field != {1'b0, $past(cas_cfg)}));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .PWRUP_CYC(PWRUP_CYC), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .mem_stall(mem_stall),
  .en(reg_rdata[4]), .done(reg_rdata[3]),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .a10(sd_a[10]), .cl_field(sd_a[6:4]), .ba(sd_ba),
  .cas_cfg(cas_cfg), .cas_err(cas_err)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
  localparam int PW = 64, TRP = 3, TRFC = 7, TMRD = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;
  localparam int NV = 6;
  localparam logic [15:0] VADDR [NV] = '{16'h4002, 16'hFFFE, 16'h2000, 16'h8A5A, 16'h1FFE, 16'h0442};
  localparam logic [12:0] VSA   [NV] = '{13'h0001, 13'h1FFF, 13'h1000, 13'h052D, 13'h0FFF, 13'h0221};
  localparam logic [1:0]  VBA   [NV] = '{2'd1, 2'd3, 2'd0, 2'd2, 2'd0, 2'd0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, mem_wr = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic [15:0] addr = '0;
  logic mem_stall, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, cas_err;
  logic [1:0] cas_cfg = 2'd2;
  logic [1:0] sd_ba;
  logic [12:0] sd_a;
  int cyc = 0, checks = 0, errors = 0, t_iss = 0, t_prev = 0;

  sdram_init_seq #(.PWRUP_CYC(PW), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .ADDR_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_wr(mem_wr), .mem_addr(addr[15:1]), .mem_stall(mem_stall), .cas_cfg(cas_cfg),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .cas_err(cas_err));

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic logic [3:0] cmd();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a);
    @(negedge clk); mem_wr = 1'b1; addr = a; #1;
    while (mem_stall) begin @(negedge clk); #1; end
    @(negedge clk); mem_wr = 1'b0;
    t_prev = t_iss; t_iss = cyc;
  endtask

  task automatic poke(input logic [15:0] a, input string req);
    @(negedge clk); mem_wr = 1'b1; addr = a; #1;
    chk({req, " no stall"}, mem_stall, 0);
    @(negedge clk); mem_wr = 1'b0;
    chk({req, " no command"}, cmd(), C_NOP);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 cke", sd_cke, 1);
    chk("R1 cmd", cmd(), C_NOP);
    chk("R1 cas_err", cas_err, 0);

    reg_write(5'h01);
    poke(16'h0000, "R8 disabled");
    reg_write(5'h10);
    poke(16'h0000, "R8 unarmed");

    reg_write(5'h17);
    chk("R2 rdata armed", reg_rdata, 5'h17);
    wr(16'h0000);
    chk("R6 first issue edge", t_iss, PW + 1);
    chk("R5 precharge first", cmd(), C_PRE);
    chk("R4 pall a10", sd_a[10], 1);
    chk("R4 pall bank", sd_ba, 0);
    @(negedge clk);
    chk("R3 one cycle", cmd(), C_NOP);
    wr(16'h0000);
    chk("R7 tRP gap", t_iss - t_prev, TRP);

    reg_write(5'h16);
    wr(16'h0000);
    chk("R5 refresh before mode", cmd(), C_REF);
    wr(16'h0000);
    chk("R7 tRFC gap", t_iss - t_prev, TRFC);
    chk("R9 not done yet", reg_rdata[3], 0);

    reg_write(5'h14);
    wr(16'h8040);
    chk("R3 emrs code", cmd(), C_MRS);
    chk("R4 emrs bank", sd_ba, 2);
    chk("R9 emrs no done", reg_rdata[3], 0);
    wr(16'h0442);
    chk("R7 tMRD gap", t_iss - t_prev, TMRD);
    chk("R4 mrs addr", sd_a, 13'h0221);
    chk("R4 mrs bank", sd_ba, 0);
    chk("R11 cl match", cas_err, 0);
    chk("R9 done set", reg_rdata[3], 1);
    chk("R2 rdata done", reg_rdata, 5'h1C);
    reg_write(5'h10);
    chk("R2 arms cleared", reg_rdata, 5'h18);

    reg_write(5'h14);
    for (int i = 0; i < NV; i++) begin
      wr(VADDR[i]);
      chk("R3 vector cmd", cmd(), C_MRS);
      chk("R4 vector addr", sd_a, VSA[i]);
      chk("R4 vector bank", sd_ba, VBA[i]);
    end

    wr(16'h0462);
    chk("R11 mismatch", cas_err, 1);
    wr(16'h8000);
    chk("R11 emrs keeps flag", cas_err, 1);
    wr(16'h0442);
    chk("R11 match clears", cas_err, 0);
    wr(16'h0462);
    chk("R11 mismatch again", cas_err, 1);
    reg_write(5'h00);
    chk("R10 rdata cleared", reg_rdata, 0);
    chk("R10 cas_err cleared", cas_err, 0);
    reg_write(5'h14);
    wr(16'h0442);
    chk("R10 history cleared", reg_rdata[3], 0);
    chk("R9 needs pre and ref", reg_rdata, 5'h14);
    chk("R1 cke held", sd_cke, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule